// File: doc/BRIEF.md
# Single-Bus Datapath Arithmetic and Logic Unit

This block is the arithmetic and logic unit of a 32-bit processor datapath that moves every value over one shared bus. One operand sits in a holding register that was loaded from the bus in an earlier step. The other operand is whatever the bus carries in the current step. When the execute strobe is high, the unit applies the operation named by a 4-bit code. It writes a 64-bit result into an output register pair: a high word and a low word.

Multiply places the full signed product across both words. Divide places the signed quotient in the low word and the remainder in the high word. Every other operation writes only the low word and clears the high word. A divide-by-zero flag is registered together with the result, so the control logic can raise an exception. The unit holds its result until the next execute strobe, which lets the sequencer move the two halves onto the bus in later steps.

Top module: `bus_alu`

## Requirements
- R1: A synchronous active-high reset clears `z_hi`, `z_lo` and `div_zero` to zero on the next rising edge. Reset takes priority over `exec`.
- R2: The outputs change only on a rising edge with `exec` high, and they show the result of the inputs present at that edge. While `exec` is low, the outputs hold their values.
- R3: Code 0 is bitwise AND of `y_opnd` and `bus_opnd`. Code 1 is bitwise OR. Code 11 is the bitwise inverse of `bus_opnd`.
- R4: Code 2 is `y_opnd + bus_opnd` and code 3 is `y_opnd - bus_opnd`, both wrapping modulo 2^32. Code 10 is the two's-complement negation of `bus_opnd`.
- R5: Code 4 is a signed multiply. The 64-bit product has its upper word in `z_hi` and its lower word in `z_lo`.
- R6: Code 5 is a signed divide of `y_opnd` by `bus_opnd`. The quotient goes to `z_lo`, truncated toward zero, and the remainder goes to `z_hi`, carrying the dividend's sign. The case 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R7: Code 5 with a zero `bus_opnd` sets `div_zero` and forces both result words to zero. Any other executed operation clears `div_zero`.
- R8: Code 6 is a logical right shift of `y_opnd` that fills with zeros. Code 7 is a left shift. The shift amount is `bus_opnd[4:0]`, and the upper bits of `bus_opnd` are ignored.
- R9: Code 8 rotates `y_opnd` right and code 9 rotates it left, by `bus_opnd[4:0]` positions. An amount of zero returns the operand unchanged.
- R10: Every operation other than codes 4 and 5 leaves `z_hi` at zero. The unused codes 12 to 15 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| exec | input | 1 | Execute strobe; loads the result registers |
| op | input | 4 | Operation code |
| y_opnd | input | 32 | Operand held in the bus holding register |
| bus_opnd | input | 32 | Operand currently on the bus |
| z_hi | output | 32 | Result high word (product high, remainder) |
| z_lo | output | 32 | Result low word (main result, quotient) |
| div_zero | output | 1 | Divide-by-zero flag for the last executed operation |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- Negative dividends: a design that floors the quotient or makes the remainder positive would return -4 and 3 instead of -3 and -2.
- The single overflowing quotient, most-negative divided by -1: an unguarded divider would produce an undefined value there.
- Division by zero: a unit that forgets to force the result would leak garbage into the result words, and one that never clears the flag would leave it latched.
- Shift and rotate amounts with bit 5 set: an arithmetic right shift, or an amount decoded from more than five bits, would return zero or a sign-filled word.
- A multiply with a negative operand: an unsigned multiply would leave a wrong high word.
- Hold with the strobe low: a design that loads its registers on every cycle would overwrite the stored result.

// File: rtl/bus_alu_pkg.sv
package bus_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_ADD = 4'd2,
    OP_SUB = 4'd3,
    OP_MUL = 4'd4,
    OP_DIV = 4'd5,
    OP_SHR = 4'd6,
    OP_SHL = 4'd7,
    OP_ROR = 4'd8,
    OP_ROL = 4'd9,
    OP_NEG = 4'd10,
    OP_NOT = 4'd11
  } alu_op_e;
endpackage

// File: rtl/alu_word_ops.sv
module alu_word_ops
  import bus_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);
  localparam int SHW = $clog2(W);

  logic [SHW-1:0] amt;
  logic [2*W-1:0] dbl_r;
  logic [2*W-1:0] dbl_l;

  assign amt   = b[SHW-1:0];
  assign dbl_r = {a, a} >> amt;
  assign dbl_l = {a, a} << amt;

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_NEG:  res = {W{1'b0}} - b;
      OP_NOT:  res = ~b;
      OP_SHR:  res = a >> amt;
      OP_SHL:  res = a << amt;
      OP_ROR:  res = dbl_r[W-1:0];
      OP_ROL:  res = dbl_l[2*W-1:W];
      default: res = {W{1'b0}};
    endcase
  end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod,
  output logic [W-1:0]   quot,
  output logic [W-1:0]   rem,
  output logic           dz
);
  logic signed [2*W-1:0] a_ext, b_ext;
  logic signed [W-1:0]   dvd, dvs, q_s, r_s;
  logic                  ovf;

  assign a_ext = $signed({{W{a[W-1]}}, a});
  assign b_ext = $signed({{W{b[W-1]}}, b});
  assign prod  = a_ext * b_ext;

  assign dz  = (b == {W{1'b0}});
  assign ovf = (a == {1'b1, {(W-1){1'b0}}}) && (b == {W{1'b1}});

  // Guarded divisor: zero and the overflow case divide by one instead.
  assign dvd = $signed(a);
  assign dvs = (dz || ovf) ? $signed({{(W-1){1'b0}}, 1'b1}) : $signed(b);

  always_comb begin
    q_s = dvd / dvs;
    r_s = dvd % dvs;
  end

  assign quot = dz ? {W{1'b0}} : q_s;
  assign rem  = dz ? {W{1'b0}} : r_s;
endmodule

// File: rtl/bus_alu.sv
module bus_alu
  import bus_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec,
  input  logic [3:0]   op,
  input  logic [W-1:0] y_opnd,
  input  logic [W-1:0] bus_opnd,
  output logic [W-1:0] z_hi,
  output logic [W-1:0] z_lo,
  output logic         div_zero
);
  alu_op_e        op_e;
  logic [W-1:0]   word_res;
  logic [2*W-1:0] prod;
  logic [W-1:0]   quot, rem;
  logic           dz;
  logic [W-1:0]   nxt_hi, nxt_lo;
  logic           nxt_dz;

  assign op_e = alu_op_e'(op);

  alu_word_ops #(.W(W)) u_word (
    .op (op_e),
    .a  (y_opnd),
    .b  (bus_opnd),
    .res(word_res)
  );

  alu_muldiv #(.W(W)) u_md (
    .a   (y_opnd),
    .b   (bus_opnd),
    .prod(prod),
    .quot(quot),
    .rem (rem),
    .dz  (dz)
  );

  always_comb begin
    nxt_dz = 1'b0;
    case (op_e)
      OP_MUL: begin
        nxt_hi = prod[2*W-1:W];
        nxt_lo = prod[W-1:0];
      end
      OP_DIV: begin
        nxt_hi = rem;
        nxt_lo = quot;
        nxt_dz = dz;
      end
      default: begin
        nxt_hi = {W{1'b0}};
        nxt_lo = word_res;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      z_hi     <= {W{1'b0}};
      z_lo     <= {W{1'b0}};
      div_zero <= 1'b0;
    end else if (exec) begin
      z_hi     <= nxt_hi;
      z_lo     <= nxt_lo;
      div_zero <= nxt_dz;
    end
  end
endmodule

// File: rtl/bus_alu_chk.sv
module bus_alu_chk
  import bus_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         exec,
  input logic [3:0]   op,
  input logic [W-1:0] y_opnd,
  input logic [W-1:0] bus_opnd,
  input logic [W-1:0] z_hi,
  input logic [W-1:0] z_lo,
  input logic         div_zero
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: one edge after a reset edge the outputs are clear
  always @(posedge clk) begin
    if (rst_q === 1'b1)
      a_r1_reset_clear: assert (z_hi == '0 && z_lo == '0 && div_zero == 1'b0)
        else $error("reset did not clear outputs");
  end

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !exec |=> ($stable(z_hi) && $stable(z_lo) && $stable(div_zero)));

  a_r4_neg_bus: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_NEG) |=> (z_lo == {W{1'b0}} - $past(bus_opnd)));

  a_r7_div_zero_set: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_DIV && bus_opnd == '0) |=> (div_zero && z_hi == '0 && z_lo == '0));

  a_r7_div_zero_clear: assert property (@(posedge clk) disable iff (rst)
    (exec && !(op == OP_DIV && bus_opnd == '0)) |=> !div_zero);

  a_r10_single_word_hi: assert property (@(posedge clk) disable iff (rst)
    (exec && op != OP_MUL && op != OP_DIV) |=> (z_hi == '0));
endmodule

bind bus_alu bus_alu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_bus_alu.sv
`timescale 1ns/1ps
module sim_bus_alu;
  localparam int W  = 32;
  localparam int NV = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         exec = 1'b0;
  logic [3:0]   op = 4'd0;
  logic [W-1:0] y_opnd = '0;
  logic [W-1:0] bus_opnd = '0;
  logic [W-1:0] z_hi, z_lo;
  logic         div_zero;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bus_alu #(.W(W)) u0 (
    .clk(clk), .rst(rst), .exec(exec), .op(op),
    .y_opnd(y_opnd), .bus_opnd(bus_opnd),
    .z_hi(z_hi), .z_lo(z_lo), .div_zero(div_zero)
  );

  // {op, y, bus, exp_hi, exp_lo, exp_dz}
  localparam logic [132:0] VEC [NV] = '{
    {4'd0,  32'hF0F0_1234, 32'h0FF0_FF00, 32'h0, 32'h00F0_1200, 1'b0},
    {4'd1,  32'hF000_0001, 32'h000F_0010, 32'h0, 32'hF00F_0011, 1'b0},
    {4'd2,  32'hFFFF_FFFF, 32'h0000_0002, 32'h0, 32'h0000_0001, 1'b0},
    {4'd3,  32'h0000_0005, 32'h0000_0007, 32'h0, 32'hFFFF_FFFE, 1'b0},
    {4'd4,  32'hFFFF_FFFE, 32'h0000_0003, 32'hFFFF_FFFF, 32'hFFFF_FFFA, 1'b0},
    {4'd4,  32'h0001_0000, 32'h0001_0000, 32'h0000_0001, 32'h0000_0000, 1'b0},
    {4'd5,  32'h0000_0011, 32'h0000_0005, 32'h0000_0002, 32'h0000_0003, 1'b0},
    {4'd5,  32'hFFFF_FFEF, 32'h0000_0005, 32'hFFFF_FFFE, 32'hFFFF_FFFD, 1'b0},
    {4'd5,  32'h0000_0007, 32'h0000_0000, 32'h0, 32'h0, 1'b1},
    {4'd5,  32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'h8000_0000, 1'b0},
    {4'd6,  32'h8000_00F0, 32'h0000_0024, 32'h0, 32'h0800_000F, 1'b0},
    {4'd7,  32'h8000_000F, 32'h0000_0004, 32'h0, 32'h0000_00F0, 1'b0},
    {4'd8,  32'h0000_00F1, 32'h0000_0004, 32'h0, 32'h1000_000F, 1'b0},
    {4'd9,  32'hF000_0001, 32'h0000_0024, 32'h0, 32'h0000_001F, 1'b0},
    {4'd10, 32'h0000_1234, 32'h0000_0001, 32'h0, 32'hFFFF_FFFF, 1'b0},
    {4'd11, 32'h1234_5678, 32'h0F0F_0000, 32'h0, 32'hF0F0_FFFF, 1'b0},
    {4'd8,  32'hABCD_1234, 32'h0000_0020, 32'h0, 32'hABCD_1234, 1'b0},
    {4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0}
  };

  function automatic string req_of(input logic [3:0] c, input logic [W-1:0] bv);
    case (c)
      4'd0, 4'd1, 4'd11: return "R3";
      4'd2, 4'd3, 4'd10: return "R4";
      4'd4:              return "R5";
      4'd5:              return (bv == '0) ? "R7" : "R6";
      4'd6, 4'd7:        return "R8";
      4'd8, 4'd9:        return "R9";
      default:           return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [64:0] got, input logic [64:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got hi=%h lo=%h dz=%b, expected hi=%h lo=%h dz=%b",
               req, got[64:33], got[32:1], got[0], exp[64:33], exp[32:1], exp[0]);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [W-1:0] yv, input logic [W-1:0] bv);
    @(negedge clk);
    op = c; y_opnd = yv; bus_opnd = bv; exec = 1'b1;
    @(negedge clk);
    exec = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {z_hi, z_lo, div_zero}, 65'd0);
    rst = 1'b0;

    // Table of vectors, one executed operation each
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][132:129], VEC[i][128:97], VEC[i][96:65]);
      check(req_of(VEC[i][132:129], VEC[i][96:65]), {z_hi, z_lo, div_zero}, VEC[i][64:0]);
    end

    // R2: result held while exec is low
    apply(4'd4, 32'h0000_0003, 32'hFFFF_FFFF);
    check("R5", {z_hi, z_lo, div_zero}, {32'hFFFF_FFFF, 32'hFFFF_FFFD, 1'b0});
    op = 4'd0; y_opnd = 32'h1111_1111; bus_opnd = 32'h0;
    repeat (3) @(negedge clk);
    check("R2", {z_hi, z_lo, div_zero}, {32'hFFFF_FFFF, 32'hFFFF_FFFD, 1'b0});

    // R7: flag set, then held while idle, then cleared by the next operation
    apply(4'd5, 32'h1234_0000, 32'h0);
    check("R7", {z_hi, z_lo, div_zero}, {64'h0, 1'b1});
    @(negedge clk);
    check("R2", {z_hi, z_lo, div_zero}, {64'h0, 1'b1});
    apply(4'd1, 32'h0000_00A0, 32'h0000_000B);
    check("R7", {z_hi, z_lo, div_zero}, {32'h0, 32'h0000_00AB, 1'b0});

    // R6: negative divisor, positive dividend
    apply(4'd5, 32'h0000_0011, 32'hFFFF_FFFB);
    check("R6", {z_hi, z_lo, div_zero}, {32'h0000_0002, 32'hFFFF_FFFD, 1'b0});

    // R1: reset wins over exec mid-run
    @(negedge clk);
    op = 4'd2; y_opnd = 32'h5; bus_opnd = 32'h6; exec = 1'b1; rst = 1'b1;
    @(negedge clk);
    exec = 1'b0; rst = 1'b0;
    check("R1", {z_hi, z_lo, div_zero}, 65'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule